// File: doc/BRIEF.md
# Multi-Line Transmit Buffer Controller

This block holds outgoing characters for eight serial lines and hands them to the per-line serializers. The host sees it through two words on a small register bus. The select word (address 0) picks a line and one of that line's indirect registers. The data word (address 1) then reaches the register that was picked. Through the data word the host fills a line's 32-character buffer one byte at a time, or rewrites the line's control byte.

A round-robin scheduler moves characters to the serializers. It sends one character per grant, and at most one character in each clock cycle. Each line can be started, stopped, held in break or flushed on its own. When a line runs dry after sending, or when a flush completes, the block queues a report that carries the line number. The host collects these reports by reading the select word. When the report queue is full, the block stops sending until the host reads a report.

Each serializer has a valid/ready handshake. A serializer raises `tx_ready` whenever it can take a character, and that signal must not depend on `tx_valid`. The controller raises `tx_valid` for a line only in a cycle where that line's `tx_ready` is already high. So every valid beat is a completed transfer, and no back-pressure is held across cycles.

Top module: `txbuf_ctrl`

## Requirements
- R1: A write to the select word (bus_addr 0) loads the indirect address from bits 4:0, where bits 2:0 give the line and bits 4:3 give the register (00 = character buffer, 01 = line control), and loads the interrupt enable from bit 14. A read of the select word returns the indirect address in bits 4:0 and the interrupt enable in bit 14.
- R2: With register 00 selected, a data-word write appends bits 7:0 to the line's buffer, which holds 32 characters. A write to a full buffer is dropped. A data-word read returns the line's fill count.
- R3: With register 01 selected, a data-word write stores bits 5:0 as the line-control byte: bit 0 transmit enable, bit 1 automatic flow control, bit 2 receive enable, bit 3 break, bit 4 flush, bit 5 modem interrupt enable. A data-word read returns that byte.
- R4: The scheduler serves eligible lines round robin, starting after the line granted last, with line 0 first after reset. A line is eligible when its buffer is not empty, its serializer is ready, transmit enable is set and break is clear.
- R5: `tx_valid` is one-hot or zero, is raised only with the matching `tx_ready`, and carries each line's characters on `tx_data` in the order they were written.
- R6: A line whose transmit enable is clear sends nothing, and its buffered characters are kept.
- R7: Setting the flush bit empties that line's buffer, queues a report for that line, and clears the flush bit. No line sends while any flush is pending.
- R8: The break bit drives the line's `brk_out` high, and that line sends nothing while break is set.
- R9: A report is queued when a grant takes a line's buffer from one character to empty, unless a host write refills the buffer in the same cycle. An idle empty line queues nothing.
- R10: A select-word read returns bit 15 set when a report is pending, with the oldest report's line in bits 10:8, and removes that report. Reports are held in arrival order, up to 8. While the queue is full, no character is sent and no flush completes.
- R11: `tx_irq` is high while the interrupt enable is set and a report is pending.
- R12: After reset the buffers and report queue are empty, all control bits and the select word are zero, and `tx_valid`, `brk_out` and `tx_irq` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe (a select-word read removes a report) |
| bus_addr | input | 1 | 0 = select/status word, 1 = indirect data word |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational on the current address |
| tx_valid | output | 8 | One-hot character offer, one bit per line |
| tx_ready | input | 8 | Serializer can take a character, one bit per line |
| tx_data | output | 8 | Character for the line that is offered |
| brk_out | output | 8 | Per-line forced-space (break) condition |
| tx_irq | output | 1 | Report pending with interrupt enabled |

## Verification
The assertions check the handshake rules on every cycle. They confirm that at most one line is offered and only to a ready serializer. They confirm that lines that are disabled, in break or waiting on a flush stay silent. They also confirm that the report queue never takes a push while full, and that a queued report is never lost. The bench scenarios are the only way to show the rest: round-robin order across lines, character order within a line, the fill counts after overfill, break and flush, the exact report contents and their order, and the sending stall when the queue is full and its release once a report is read.

// File: rtl/txbuf_pkg.sv
package txbuf_pkg;
  localparam int unsigned LINES  = 8;
  localparam int unsigned LINE_W = $clog2(LINES);
  localparam int unsigned CHAR_W = 8;
  localparam int unsigned LC_W   = 6;

  // indirect register select, bits 4:3 of the indirect address
  typedef enum logic [1:0] {
    IR_CHARBUF = 2'b00,
    IR_LINECTL = 2'b01
  } ir_sel_e;

  // line-control bit positions
  localparam int unsigned LC_TXEN  = 0;
  localparam int unsigned LC_AUTOX = 1;
  localparam int unsigned LC_RXEN  = 2;
  localparam int unsigned LC_BRK   = 3;
  localparam int unsigned LC_FLUSH = 4;
  localparam int unsigned LC_MIE   = 5;

  // select/status word bit positions
  localparam int unsigned ST_RDY = 15;
  localparam int unsigned ST_TIE = 14;
endpackage

// File: rtl/tx_line_fifo.sv
module tx_line_fifo #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned W     = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [W-1:0]               din,
  input  logic                       pop,
  input  logic                       clr,
  output logic [W-1:0]               dout,
  output logic [$clog2(DEPTH):0]     count,
  output logic                       empty
);
  localparam int unsigned PW = $clog2(DEPTH);
  localparam int unsigned CW = PW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic          do_push, do_pop;

  assign empty   = (count == '0);
  assign do_push = push && (count != CW'(DEPTH)) && !clr;
  assign do_pop  = pop && !empty && !clr;
  assign dout    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= wp + PW'(1);
      if (do_pop)  rp <= rp + PW'(1);
      if (do_push && !do_pop)      count <= count + CW'(1);
      else if (do_pop && !do_push) count <= count - CW'(1);
    end
  end
endmodule

// File: rtl/rr_arbiter.sv
module rr_arbiter #(
  parameter int unsigned N = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N-1:0]         req,
  output logic [N-1:0]         gnt,
  output logic [$clog2(N)-1:0] gnt_idx,
  output logic                 gnt_v
);
  localparam int unsigned IW = $clog2(N);

  logic [IW-1:0] last;

  always_comb begin
    int c;
    gnt     = '0;
    gnt_v   = 1'b0;
    gnt_idx = '0;
    for (int k = 1; k <= int'(N); k++) begin
      c = int'(last) + k;
      if (c >= int'(N)) c = c - int'(N);
      if (!gnt_v && req[c]) begin
        gnt_v   = 1'b1;
        gnt_idx = IW'(c);
      end
    end
    if (gnt_v) gnt[gnt_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     last <= IW'(N - 1);
    else if (gnt_v) last <= gnt_idx;
  end
endmodule

// File: rtl/report_queue.sv
module report_queue #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned W     = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);
  localparam int unsigned PW = $clog2(DEPTH);
  localparam int unsigned CW = PW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  assign empty   = (cnt == '0);
  assign full    = (cnt == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= wp + PW'(1);
      if (do_pop)  rp <= rp + PW'(1);
      if (do_push && !do_pop)      cnt <= cnt + CW'(1);
      else if (do_pop && !do_push) cnt <= cnt - CW'(1);
    end
  end
endmodule

// File: rtl/txbuf_ctrl.sv
module txbuf_ctrl
  import txbuf_pkg::*;
#(
  parameter int unsigned BUF_DEPTH = 32,
  parameter int unsigned RPT_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic              bus_addr,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  output logic [LINES-1:0]  tx_valid,
  input  logic [LINES-1:0]  tx_ready,
  output logic [CHAR_W-1:0] tx_data,
  output logic [LINES-1:0]  brk_out,
  output logic              tx_irq
);
  localparam int unsigned CW = $clog2(BUF_DEPTH) + 1;

  // host-visible state
  logic [4:0]      iaddr;
  logic            tie;
  logic [LC_W-1:0] lctl [LINES];

  logic [LINE_W-1:0] line_sel;
  ir_sel_e           reg_sel;
  logic              wr_csr, wr_ind, rd_csr;

  assign line_sel = iaddr[LINE_W-1:0];
  assign reg_sel  = ir_sel_e'(iaddr[4:3]);
  assign wr_csr   = bus_we && !bus_addr;
  assign wr_ind   = bus_we && bus_addr;
  assign rd_csr   = bus_re && !bus_addr;

  logic unused_wbits;
  assign unused_wbits = ^{bus_wdata[15], bus_wdata[13:8]};

  // per-line buffers
  logic [LINES-1:0]  buf_push, buf_pop, buf_clr, buf_empty;
  logic [CHAR_W-1:0] buf_head [LINES];
  logic [CW-1:0]     buf_cnt  [LINES];
  logic [LINES-1:0]  te_vec, flush_req, elig;

  logic              rq_push, rq_pop, rq_empty, rq_full;
  logic [LINE_W-1:0] rq_din, rq_head;

  logic              fl_any, fl_do;
  logic [LINE_W-1:0] fl_idx;

  logic [LINES-1:0]  gnt;
  logic [LINE_W-1:0] gnt_idx;
  logic              gnt_v;
  logic              drain_evt;

  for (genvar i = 0; i < LINES; i++) begin : g_line
    assign buf_push[i]  = wr_ind && (reg_sel == IR_CHARBUF) && (line_sel == LINE_W'(i));
    assign buf_clr[i]   = fl_do && (fl_idx == LINE_W'(i));
    assign te_vec[i]    = lctl[i][LC_TXEN];
    assign flush_req[i] = lctl[i][LC_FLUSH];
    assign brk_out[i]   = lctl[i][LC_BRK];
    assign elig[i]      = !buf_empty[i] && tx_ready[i] && te_vec[i] &&
                          !lctl[i][LC_BRK] && !fl_any && !rq_full;

    tx_line_fifo #(.DEPTH(BUF_DEPTH), .W(CHAR_W)) u_buf (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (buf_push[i]),
      .din   (bus_wdata[CHAR_W-1:0]),
      .pop   (buf_pop[i]),
      .clr   (buf_clr[i]),
      .dout  (buf_head[i]),
      .count (buf_cnt[i]),
      .empty (buf_empty[i])
    );
  end

  // flush engine: lowest pending line completes once the queue has room
  assign fl_any = |flush_req;
  assign fl_do  = fl_any && !rq_full;
  always_comb begin
    fl_idx = '0;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (flush_req[i]) fl_idx = LINE_W'(i);
    end
  end

  rr_arbiter #(.N(LINES)) u_sched (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (elig),
    .gnt     (gnt),
    .gnt_idx (gnt_idx),
    .gnt_v   (gnt_v)
  );

  assign buf_pop  = gnt;
  assign tx_valid = gnt;
  assign tx_data  = buf_head[gnt_idx];

  // last character leaves and no refill arrives in the same cycle
  assign drain_evt = gnt_v && (buf_cnt[gnt_idx] == CW'(1)) && !buf_push[gnt_idx];
  assign rq_push   = fl_do || drain_evt;
  assign rq_din    = fl_do ? fl_idx : gnt_idx;
  assign rq_pop    = rd_csr && !rq_empty;

  report_queue #(.DEPTH(RPT_DEPTH), .W(LINE_W)) u_rpt (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (rq_push),
    .din   (rq_din),
    .pop   (rq_pop),
    .head  (rq_head),
    .empty (rq_empty),
    .full  (rq_full)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      iaddr <= '0;
      tie   <= 1'b0;
    end else if (wr_csr) begin
      iaddr <= bus_wdata[4:0];
      tie   <= bus_wdata[ST_TIE];
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < LINES; i++) begin
      if (!rst_n) begin
        lctl[i] <= '0;
      end else begin
        if (buf_clr[i]) lctl[i][LC_FLUSH] <= 1'b0;
        if (wr_ind && (reg_sel == IR_LINECTL) && (line_sel == LINE_W'(i)))
          lctl[i] <= bus_wdata[LC_W-1:0];
      end
    end
  end

  assign tx_irq = tie && !rq_empty;

  always_comb begin
    bus_rdata = '0;
    if (!bus_addr) begin
      bus_rdata[ST_RDY] = !rq_empty;
      bus_rdata[ST_TIE] = tie;
      if (!rq_empty) bus_rdata[8 +: LINE_W] = rq_head;
      bus_rdata[4:0] = iaddr;
    end else begin
      case (reg_sel)
        IR_CHARBUF: bus_rdata = 16'(buf_cnt[line_sel]);
        IR_LINECTL: bus_rdata = 16'(lctl[line_sel]);
        default:    bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/txbuf_ctrl_chk.sv
module txbuf_ctrl_chk #(
  parameter int unsigned N = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] tx_valid,
  input logic [N-1:0] tx_ready,
  input logic [N-1:0] brk_out,
  input logic [N-1:0] te_vec,
  input logic [N-1:0] flush_req,
  input logic         rq_push,
  input logic         rq_full,
  input logic         rq_empty
);
  p_one_offer_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tx_valid));

  p_offer_needs_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid & ~tx_ready) == '0);

  p_break_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid & brk_out) == '0);

  p_disabled_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid & ~te_vec) == '0);

  p_flush_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_req != '0) |-> (tx_valid == '0));

  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rq_full |-> !rq_push);

  p_full_stalls_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rq_full |-> (tx_valid == '0));

  p_report_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rq_push |=> !rq_empty);
endmodule

bind txbuf_ctrl txbuf_ctrl_chk #(.N(txbuf_pkg::LINES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tx_valid  (tx_valid),
  .tx_ready  (tx_ready),
  .brk_out   (brk_out),
  .te_vec    (te_vec),
  .flush_req (flush_req),
  .rq_push   (rq_push),
  .rq_full   (rq_full),
  .rq_empty  (rq_empty)
);

// File: tb/tb_txbuf_ctrl.sv
module tb_txbuf_ctrl;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0, bus_re = 1'b0, bus_addr = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [7:0]  tx_valid, tx_ready, brk_out;
  logic [7:0]  tx_data;
  logic        tx_irq;

  int nchk = 0, nerr = 0;
  bit done = 0;
  logic       tie_b = 1'b0;
  logic [4:0] cur_ia = '0;
  logic [7:0] exp_q [8][$];
  int         obs [$];

  txbuf_ctrl dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .brk_out(brk_out), .tx_irq(tx_irq)
  );

  always #(PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // monitor: scoreboard pop and compare on every transfer
  always @(negedge clk) begin
    if (rst_n) begin
      for (int i = 0; i < 8; i++) begin
        if (tx_valid[i]) begin
          obs.push_back(i);
          chk(tx_ready[i] == 1'b1, "R5 offer without ready", i, i);
          if (exp_q[i].size() == 0) begin
            chk(1'b0, "R5 unexpected character", int'(tx_data), -1);
          end else begin
            logic [7:0] e;
            e = exp_q[i].pop_front();
            chk(tx_data == e, "R5 character order", int'(tx_data), int'(e));
          end
        end
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic waitc(input int n);
    repeat (n) tick();
  endtask

  task automatic csr_wr(input logic [4:0] ia);
    cur_ia = ia;
    bus_addr = 1'b0; bus_wdata = {1'b0, tie_b, 9'b0, ia}; bus_we = 1'b1;
    tick();
    bus_we = 1'b0;
  endtask

  task automatic ind_wr(input logic [15:0] v);
    bus_addr = 1'b1; bus_wdata = v; bus_we = 1'b1;
    tick();
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [15:0] v);
    bus_addr = a; bus_re = 1'b1;
    @(negedge clk);
    v = bus_rdata;
    tick();
    bus_re = 1'b0;
  endtask

  task automatic put_byte(input int line, input logic [7:0] b, input bit accept);
    csr_wr({2'b00, 3'(line)});
    ind_wr({8'h00, b});
    if (accept) exp_q[line].push_back(b);
  endtask

  task automatic set_lc(input int line, input logic [5:0] v);
    csr_wr({2'b01, 3'(line)});
    ind_wr({10'b0, v});
  endtask

  task automatic get_reg(input int line, input logic [1:0] sel, output logic [15:0] v);
    csr_wr({sel, 3'(line)});
    rd(1'b1, v);
  endtask

  task automatic exp_status(input int line, input string req);
    logic [15:0] v, e;
    e = {1'b1, tie_b, 3'b0, 3'(line), 3'b0, cur_ia};
    rd(1'b0, v);
    chk(v == e, req, int'(v), int'(e));
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    tx_ready = 8'h00;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick();

    // R12 reset state
    @(negedge clk);
    chk(tx_valid == 8'h00, "R12 tx_valid", tx_valid, 0);
    chk(brk_out == 8'h00, "R12 brk_out", brk_out, 0);
    chk(tx_irq == 1'b0, "R12 tx_irq", tx_irq, 0);
    tick();
    rd(1'b0, v);
    chk(v == 16'h0000, "R12 select word", v, 0);
    get_reg(3, 2'b01, v);
    chk(v == 16'h0000, "R12 line control", v, 0);

    // R1 / R3 select and line-control readback
    tie_b = 1'b1;
    set_lc(1, 6'h26);
    get_reg(1, 2'b01, v);
    chk(v == 16'h0026, "R3 control byte readback", v, 16'h26);
    rd(1'b0, v);
    chk(v == {2'b01, 9'b0, 5'b01001}, "R1 select readback", v, {2'b01, 9'b0, 5'b01001});

    // R6 disabled line keeps data, R2 count
    tx_ready = 8'hFF;
    put_byte(2, 8'hA1, 1); put_byte(2, 8'hA2, 1); put_byte(2, 8'hA3, 1);
    waitc(5);
    get_reg(2, 2'b00, v);
    chk(v == 16'd3, "R6 characters kept while disabled", v, 3);
    set_lc(2, 6'h01);
    waitc(10);
    chk(exp_q[2].size() == 0, "R5 line 2 drained", exp_q[2].size(), 0);
    @(negedge clk);
    chk(tx_irq == 1'b1, "R11 irq with pending report", tx_irq, 1);
    tick();
    exp_status(2, "R9 drain report line 2");
    rd(1'b0, v);
    chk(v[15] == 1'b0, "R10 report popped", v[15], 0);

    // R4 round robin across lines 0,1,3
    tx_ready = 8'h00;
    put_byte(0, 8'h10, 1); put_byte(0, 8'h11, 1);
    put_byte(1, 8'h20, 1); put_byte(1, 8'h21, 1);
    put_byte(3, 8'h30, 1); put_byte(3, 8'h31, 1);
    set_lc(0, 6'h01); set_lc(1, 6'h01); set_lc(3, 6'h01);
    obs.delete();
    tx_ready = 8'hFF;
    waitc(20);
    begin
      int eo [6] = '{3, 0, 1, 3, 0, 1};
      chk(obs.size() == 6, "R4 grant count", obs.size(), 6);
      for (int k = 0; k < 6 && k < obs.size(); k++)
        chk(obs[k] == eo[k], "R4 round-robin order", obs[k], eo[k]);
    end
    exp_status(3, "R10 first report line 3");
    exp_status(0, "R10 second report line 0");
    exp_status(1, "R10 third report line 1");

    // R8 break
    put_byte(4, 8'h40, 1); put_byte(4, 8'h41, 1);
    set_lc(4, 6'h09);
    waitc(10);
    @(negedge clk);
    chk(brk_out == 8'h10, "R8 break output", brk_out, 8'h10);
    tick();
    get_reg(4, 2'b00, v);
    chk(v == 16'd2, "R8 no send during break", v, 2);
    set_lc(4, 6'h01);
    waitc(10);
    @(negedge clk);
    chk(brk_out == 8'h00, "R8 break released", brk_out, 0);
    tick();
    exp_status(4, "R9 report after break release");

    // R7 flush
    put_byte(5, 8'h50, 0); put_byte(5, 8'h51, 0); put_byte(5, 8'h52, 0);
    set_lc(5, 6'h10);
    waitc(3);
    get_reg(5, 2'b01, v);
    chk(v == 16'h0000, "R7 flush bit self-clears", v, 0);
    get_reg(5, 2'b00, v);
    chk(v == 16'd0, "R7 buffer emptied", v, 0);
    exp_status(5, "R7 flush report line 5");
    set_lc(5, 6'h01);
    waitc(5);

    // R9 idle empty line gives no report
    set_lc(6, 6'h01);
    waitc(5);
    rd(1'b0, v);
    chk(v[15] == 1'b0, "R9 no report for idle line", v[15], 0);

    // R2 overfill
    for (int k = 0; k < 34; k++) put_byte(7, 8'(k + 8'h60), k < 32);
    get_reg(7, 2'b00, v);
    chk(v == 16'd32, "R2 full buffer count", v, 32);
    set_lc(7, 6'h01);
    waitc(50);
    chk(exp_q[7].size() == 0, "R2 first 32 sent", exp_q[7].size(), 0);
    exp_status(7, "R9 report line 7");

    // R10 queue full stall
    tx_ready = 8'h00;
    for (int i = 0; i < 8; i++) put_byte(i, 8'(8'h80 + i), 1);
    obs.delete();
    tx_ready = 8'hFF;
    waitc(20);
    chk(obs.size() == 8, "R4 eight grants", obs.size(), 8);
    for (int k = 0; k < 8 && k < obs.size(); k++)
      chk(obs[k] == k, "R4 order after line 7", obs[k], k);
    put_byte(0, 8'hC0, 1);
    waitc(10);
    get_reg(0, 2'b00, v);
    chk(v == 16'd1, "R10 no send while queue full", v, 1);
    exp_status(0, "R10 oldest report line 0");
    waitc(10);
    get_reg(0, 2'b00, v);
    chk(v == 16'd0, "R10 send resumes after read", v, 0);
    for (int k = 1; k < 8; k++) exp_status(k, "R10 queued report order");
    exp_status(0, "R10 refill report at tail");

    for (int i = 0; i < 8; i++)
      chk(exp_q[i].size() == 0, "R5 scoreboard empty", exp_q[i].size(), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule